// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a serial port that owns the clock. It generates a serial clock from a programmable divider and samples a data line on that clock's falling edges. It assembles words of 8 or 9 bits, least-significant bit first. Each finished word goes into a two-entry FIFO, and software reads the FIFO through a status view and a data strobe.

Reception runs in one of two modes. A one-shot request fetches a single word and then withdraws itself. A continuous enable keeps fetching words until it is dropped. If both are set, the continuous enable wins. A full FIFO at the end of a word raises a sticky overrun flag. The flag freezes the receiver until software drops the continuous enable. Dropping the port enable returns the whole receive path to its idle state.

Top module: `sync_master_rx`

## Requirements
- R1: The serial clock `sclk` has a period of 4×(`div`+1) cycles of `clk`, starting low, and it stays low whenever no reception is running.
- R2: The bit on `sdata` is captured on each falling edge of `sclk`, least-significant bit first. A word is 9 bits when `nine_bit` is 1 and 8 bits otherwise.
- R3: A pulse on `single_req` sets `single_busy`. Exactly one word is then received, and `single_busy` drops in the cycle that word completes.
- R4: While `cont_en` is 1, words are received back to back. `cont_en` overrides a pending one-shot request, and `single_busy` stays 1 while continuous words arrive.
- R5: A completed word is written into the two-entry FIFO when the FIFO is not full and no overrun is pending. `rx_ready` is 1 exactly while the FIFO holds at least one word.
- R6: `rx_ready` falls once data reads have emptied the FIFO, and `irq` equals `rx_ready` gated by `rie`.
- R7: If a word completes while the FIFO holds two words, `overrun` becomes 1 and that word is discarded. `sclk` then stays low and no word enters the FIFO while `overrun` is 1.
- R8: `overrun` is cleared only by a 1-to-0 change of `cont_en` or by a low `port_en`. Reads leave it set, and the words already in the FIFO remain readable.
- R9: In 9-bit mode the ninth bit is stored with its word; in 8-bit mode a 0 is stored. `rx9d` shows the ninth bit of the oldest stored word. A `data_rd` pulse pops that word onto `rd_data` one cycle later, and `rx9d` then moves to the next word.
- R10: While `port_en` is 0, the FIFO is emptied and `overrun`, `single_busy` and `sclk` are held at 0.
- R11: A `data_rd` pulse with an empty FIFO leaves `rd_data` unchanged and `rx_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low holds the receiver idle and empty |
| cont_en | input | 1 | Continuous receive enable |
| single_req | input | 1 | One-cycle pulse requesting one word |
| nine_bit | input | 1 | 1 selects 9-bit words |
| rie | input | 1 | Receive interrupt enable |
| div | input | DIV_W | Clock divider; serial period is 4×(div+1) clocks |
| sdata | input | 1 | Serial data line |
| data_rd | input | 1 | One-cycle data read strobe, pops the FIFO |
| sclk | output | 1 | Generated serial clock |
| rd_data | output | 8 | Last word popped from the FIFO |
| rx9d | output | 1 | Ninth bit of the oldest stored word |
| rx_ready | output | 1 | FIFO holds data |
| overrun | output | 1 | Sticky overrun flag |
| single_busy | output | 1 | One-shot request outstanding |
| irq | output | 1 | Receive interrupt |

## Verification
The bench receives three words in continuous mode without reading any of them. It expects the receiver to freeze with `overrun` high and the first two words intact. A design that overwrote the oldest entry or kept clocking would return the wrong data. A design that cleared the flag on a read would drop `overrun` too early. The bench also sets both enables at once. A design that gave the one-shot request priority would stop after one word and never overrun. The bench reads `rx9d` before and after a pop to catch a ninth bit taken from the wrong entry. It reads the empty FIFO to catch an underflow that corrupts `rd_data`. Finally, it measures the clock period against the divider to catch an off-by-one in the half-period count.

// File: rtl/sync_master_rx.sv
`timescale 1ns/1ps
module sync_master_rx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             cont_en,
  input  logic             single_req,
  input  logic             nine_bit,
  input  logic             rie,
  input  logic [DIV_W-1:0] div,
  input  logic             sdata,
  input  logic             data_rd,
  output logic             sclk,
  output logic [7:0]       rd_data,
  output logic             rx9d,
  output logic             rx_ready,
  output logic             overrun,
  output logic             single_busy,
  output logic             irq
);
  localparam int HW = DIV_W + 1;

  logic [HW-1:0] hcnt;
  logic [3:0]    bitcnt;
  logic [8:0]    sh;
  logic [8:0]    mem [2];
  logic          wp, rp;
  logic [1:0]    count;
  logic          ovr, single_q, cont_q;
  logic [8:0]    word;

  wire       run      = port_en && (cont_en || single_q) && !ovr;
  wire       half_end = (hcnt == {div, 1'b1});
  wire       fall     = run && half_end && sclk;
  wire [3:0] last_bit = nine_bit ? 4'd8 : 4'd7;
  wire       done     = fall && (bitcnt == last_bit);
  wire       push     = done && (count != 2'd2);
  wire       ovr_set  = done && (count == 2'd2);
  wire       pop      = port_en && data_rd && (count != 2'd0);

  always_comb begin
    word = sh;
    word[bitcnt] = sdata;
    if (!nine_bit) word[8] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      sclk     <= 1'b0;
      bitcnt   <= '0;
      sh       <= '0;
      wp       <= 1'b0;
      rp       <= 1'b0;
      count    <= '0;
      ovr      <= 1'b0;
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      rd_data  <= '0;
    end else begin
      cont_q <= cont_en;
      if (pop) rd_data <= mem[rp][7:0];
      if (!port_en) begin
        hcnt     <= '0;
        sclk     <= 1'b0;
        bitcnt   <= '0;
        wp       <= 1'b0;
        rp       <= 1'b0;
        count    <= '0;
        ovr      <= 1'b0;
        single_q <= 1'b0;
      end else begin
        if (single_req) single_q <= 1'b1;
        if (done && !cont_en) single_q <= 1'b0;

        if (run) begin
          if (half_end) begin
            hcnt <= '0;
            sclk <= ~sclk;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end else begin
          hcnt   <= '0;
          sclk   <= 1'b0;
          bitcnt <= '0;
        end

        if (fall) begin
          sh[bitcnt] <= sdata;
          bitcnt     <= done ? 4'd0 : bitcnt + 4'd1;
        end

        if (push) wp <= ~wp;
        if (pop)  rp <= ~rp;
        case ({push, pop})
          2'b10:   count <= count + 2'd1;
          2'b01:   count <= count - 2'd1;
          default: count <= count;
        endcase

        if (ovr_set) ovr <= 1'b1;
        else if (cont_q && !cont_en) ovr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= word;
  end

  assign rx9d        = mem[rp][8];
  assign rx_ready    = (count != 2'd0);
  assign overrun     = ovr;
  assign single_busy = single_q;
  assign irq         = rx_ready && rie;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 2'd2);

  p_ovr_from_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> (count == 2'd2 && $past(count) == 2'd2));

  p_halt_on_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> !sclk);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && port_en && !(cont_q && !cont_en)) |=> ovr);

  p_single_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_q) |-> ($past(!port_en) || $past(done && !cont_en)));

  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (count == 2'd0 && !ovr && !single_q && !sclk));

  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && count == 2'd0) |=> $stable(rd_data));
endmodule

// File: tb/sync_master_rx_tb_top.sv
`timescale 1ns/1ps
module sync_master_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0, cont_en = 1'b0, single_req = 1'b0, nine_bit = 1'b0, rie = 1'b0;
  logic [7:0] div = 8'd2;
  logic sdata = 1'b0, data_rd = 1'b0;
  logic sclk, rx9d, rx_ready, overrun, single_busy, irq;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [8:0] tx_words [4];
  logic slave_clr = 1'b0;
  int widx, bidx;

  always #2 clk = ~clk;

  sync_master_rx #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
    .single_req(single_req), .nine_bit(nine_bit), .rie(rie), .div(div),
    .sdata(sdata), .data_rd(data_rd), .sclk(sclk), .rd_data(rd_data),
    .rx9d(rx9d), .rx_ready(rx_ready), .overrun(overrun),
    .single_busy(single_busy), .irq(irq));

  always @(posedge sclk or posedge slave_clr) begin
    if (slave_clr) begin
      widx = 0;
      bidx = 0;
    end else begin
      sdata <= tx_words[widx % 4][bidx];
      bidx = bidx + 1;
      if (bidx == (nine_bit ? 9 : 8)) begin
        bidx = 0;
        widx = widx + 1;
      end
    end
  end

  // [10]=rie, [9]=nine_bit, [8:0]=word sent
  localparam logic [10:0] VEC [6] = '{
    11'b0_0_0_1010_0101, 11'b1_0_0_0011_1100, 11'b0_1_1_1000_0001,
    11'b1_1_0_0111_1110, 11'b1_0_1_1111_1111, 11'b0_1_1_0000_0000 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_single();
    single_req = 1'b1; @(negedge clk); single_req = 1'b0;
  endtask

  task automatic read_data(output logic [7:0] d);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic clr_slave();
    slave_clr = 1'b1; #1; slave_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R10, R1)
    chk("R10 reset rx_ready", rx_ready, 0);
    chk("R10 reset overrun", overrun, 0);
    chk("R10 reset single_busy", single_busy, 0);
    chk("R1 reset sclk", sclk, 0);
    chk("R6 reset irq", irq, 0);
    port_en = 1'b1;
    @(negedge clk);

    // table: single-word receptions (R2, R3, R5, R6, R9)
    for (int i = 0; i < 6; i++) begin
      rie = VEC[i][10];
      nine_bit = VEC[i][9];
      tx_words[0] = VEC[i][8:0];
      clr_slave();
      pulse_single();
      chk("R3 single_busy set", single_busy, 1);
      while (!rx_ready) @(negedge clk);
      chk("R3 single_busy cleared", single_busy, 0);
      chk("R6 irq gated", irq, VEC[i][10]);
      chk("R9 ninth bit", rx9d, VEC[i][9] ? VEC[i][8] : 1'b0);
      read_data(d);
      chk("R2 data lsb first", d, VEC[i][7:0]);
      chk("R6 ready cleared", rx_ready, 0);
      chk("R6 irq cleared", irq, 0);
    end

    // serial clock period and idle level (R1)
    div = 8'd5; nine_bit = 1'b0; tx_words[0] = 9'h0C3;
    clr_slave();
    pulse_single();
    @(posedge sclk); t0 = int'($time);
    @(posedge sclk); t1 = int'($time);
    chk("R1 sclk period", t1 - t0, 96);
    while (!rx_ready) @(negedge clk);
    read_data(d);
    chk("R2 data div5", d, 8'hC3);
    repeat (30) @(negedge clk);
    chk("R1 sclk idle low", sclk, 0);
    div = 8'd1;

    // continuous with overrun (R4, R5, R7, R8, R9, R11)
    nine_bit = 1'b1;
    tx_words[0] = 9'h15A; tx_words[1] = 9'h0A7; tx_words[2] = 9'h133;
    clr_slave();
    cont_en = 1'b1;
    while (!overrun) @(negedge clk);
    chk("R7 ready while overrun", rx_ready, 1);
    repeat (20) begin
      @(negedge clk);
      if (sclk !== 1'b0) chk("R7 sclk halted", sclk, 0);
    end
    chk("R9 first ninth", rx9d, 1);
    read_data(d);
    chk("R5 first word kept", d, 8'h5A);
    chk("R9 ninth moves to next", rx9d, 0);
    read_data(d);
    chk("R5 second word kept", d, 8'hA7);
    chk("R7 third word dropped", rx_ready, 0);
    chk("R8 overrun survives reads", overrun, 1);
    read_data(d);
    chk("R11 empty read holds data", d, 8'hA7);
    chk("R11 empty read ready", rx_ready, 0);
    cont_en = 1'b0;
    @(negedge clk);
    chk("R8 overrun cleared", overrun, 0);
    chk("R8 receiver idle", sclk, 0);

    // precedence with both enables, then port disable (R4, R10)
    nine_bit = 1'b0;
    tx_words[0] = 9'h011; tx_words[1] = 9'h022; tx_words[2] = 9'h033;
    clr_slave();
    cont_en = 1'b1;
    pulse_single();
    while (!overrun) @(negedge clk);
    chk("R4 continuous wins, overrun reached", overrun, 1);
    chk("R4 single_busy kept", single_busy, 1);
    read_data(d);
    chk("R4 first continuous word", d, 8'h11);
    port_en = 1'b0; cont_en = 1'b0;
    @(negedge clk);
    chk("R10 disable empties fifo", rx_ready, 0);
    chk("R10 disable clears overrun", overrun, 0);
    chk("R10 disable clears single", single_busy, 0);
    chk("R10 disable sclk low", sclk, 0);
    port_en = 1'b1;

    // receive again after recovery (R3)
    tx_words[0] = 9'h0E4;
    clr_slave();
    pulse_single();
    while (!rx_ready) @(negedge clk);
    read_data(d);
    chk("R3 receive after recovery", d, 8'hE4);

    finished = 1'b1;
    finish_run();
  end
endmodule